// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Controller

This block keeps the interrupt status flags of a seven-channel DMA engine. Each channel has four flags: a transfer-complete flag, a half-transfer flag, a transfer-error flag, and a global flag that summarises the other three. The transfer engine raises the first three with single-cycle event pulses. The global flag of each channel drives that channel's interrupt line.

Software uses a simple register bus. It reads the packed flags from a read-only status word at offset 0x00. It clears flags by writing ones to a write-only clear word at offset 0x04. Both words share one layout: channel x (1 to 7) uses the four bits that start at bit 4*(x-1). Inside each four-bit group, bit 0 is the global flag, bit 1 is transfer complete, bit 2 is half transfer and bit 3 is transfer error. The clear word holds no state, so a write acts as a one-cycle clear pulse. Writing 1 to a channel's global-clear bit removes all four of that channel's flags at once.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset, every flag is 0, every interrupt line is 0, and a status read returns 0.
- R2: An event pulse on a channel's transfer-complete, half-transfer or transfer-error input sets the matching flag one clock later. The flag appears at status bit 4*(x-1)+1, +2 or +3 for channel x.
- R3: An event pulse of any kind on a channel also sets that channel's global flag (status bit 4*(x-1)). A set sub-flag is always accompanied by a set global flag.
- R4: A write of 1 to clear-word bit 4*(x-1)+1, +2 or +3 at offset 0x04 clears only the matching flag of channel x. The channel's global flag and all other flags keep their values.
- R5: A write of 1 to clear-word bit 4*(x-1) clears all four flags of channel x in the same write.
- R6: Clear-word bits written as 0 have no effect, and bits 31:28 of the clear word are ignored.
- R7: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R8: The interrupt line of channel x (irq bit x-1) equals that channel's global flag. It goes low in the cycle after the clearing write.
- R9: A read at offset 0x04 returns 0. A write at offset 0x00 changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_tc | input | NUM_CH | Transfer-complete event pulses, bit x-1 for channel x |
| evt_ht | input | NUM_CH | Half-transfer event pulses |
| evt_te | input | NUM_CH | Transfer-error event pulses |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the read |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The assertions check these rules on every cycle:
- an event always leaves its flag set on the next cycle;
- a set sub-flag never appears without its global flag;
- a specific clear removes only its own flag;
- a global clear with no competing event empties the channel's group;
- flags that receive neither an event nor a clear hold their value;
- reads of the clear word return zero;
- the interrupt lines match the global bits seen in a status read.

Only the bench's scenarios show the following:
- the exact bit placement of each channel's group;
- that the reserved bits 31:28 and writes to the status word have no effect;
- the reset state;
- that long mixed sequences of random events and clears match an independent model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Position of each flag inside a channel's four-bit group
  localparam int FLAGS_PER_CH = 4;
  localparam int F_GIF = 0;
  localparam int F_TC  = 1;
  localparam int F_HT  = 2;
  localparam int F_TE  = 3;

  // Packed so that the bit order matches the group layout (gif at bit 0)
  typedef struct packed {
    logic te;
    logic ht;
    logic tc;
    logic gif;
  } ch_flags_t;

  // Next value of one flag: a set event has priority over a clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // Effective clear of a sub-flag: its own clear bit or the group's global clear
  function automatic logic sub_clear(logic own_clr, logic grp_clr);
    return own_clr | grp_clr;
  endfunction

  // Register offset compare
  function automatic logic offs_hit(logic [15:0] addr, logic [15:0] offs);
    return addr == offs;
  endfunction

endpackage

// File: rtl/dma_irq_clr_dec.sv
module dma_irq_clr_dec
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH  = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CLR_OFS = 4
) (
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic                           clr_hit,
  output logic [NUM_CH*FLAGS_PER_CH-1:0] clr_vec
);

  localparam int FLAG_W = NUM_CH * FLAGS_PER_CH;

  logic [15:0] addr_ext;

  assign addr_ext = 16'(bus_addr);
  assign clr_hit  = bus_sel & bus_wr & offs_hit(addr_ext, 16'(CLR_OFS));

  // One clear pulse per bit of each channel group; nothing is stored
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar b = 0; b < FLAGS_PER_CH; b++) begin : g_bit
      assign clr_vec[c*FLAGS_PER_CH + b] =
        clr_hit & bus_wdata[c*FLAGS_PER_CH + b];
    end
  end

  // Reserved upper bits of the clear word are dropped here
  if (FLAG_W < DATA_W) begin : g_rsvd
    logic unused_rsvd;
    assign unused_rsvd = ^bus_wdata[DATA_W-1:FLAG_W];
  end

endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      evt_tc,
  input  logic      evt_ht,
  input  logic      evt_te,
  input  ch_flags_t clr,
  output ch_flags_t flags,
  output logic      irq
);

  ch_flags_t flags_d;
  logic      any_evt;

  assign any_evt = evt_tc | evt_ht | evt_te;

  always_comb begin
    flags_d.tc  = flag_next(flags.tc, evt_tc, sub_clear(clr.tc, clr.gif));
    flags_d.ht  = flag_next(flags.ht, evt_ht, sub_clear(clr.ht, clr.gif));
    flags_d.te  = flag_next(flags.te, evt_te, sub_clear(clr.te, clr.gif));
    // Only the group clear removes the summary flag; any event sets it
    flags_d.gif = flag_next(flags.gif, any_evt, clr.gif);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  assign irq = flags.gif;

endmodule

// File: rtl/dma_irq_pack.sv
module dma_irq_pack
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH  = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int STS_OFS = 0
) (
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [NUM_CH*FLAGS_PER_CH-1:0] flags_vec,
  output logic [DATA_W-1:0]              bus_rdata
);

  logic rd_sts;

  assign rd_sts = bus_sel & ~bus_wr & offs_hit(16'(bus_addr), 16'(STS_OFS));

  // Status word: flag groups in the low bits, zeros above them.
  // Any other offset, including the clear word, reads as zero.
  always_comb begin
    bus_rdata = '0;
    if (rd_sts) bus_rdata = DATA_W'(flags_vec);
  end

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_tc,
  input  logic [NUM_CH-1:0] evt_ht,
  input  logic [NUM_CH-1:0] evt_te,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int FLAG_W  = NUM_CH * FLAGS_PER_CH;
  localparam int STS_OFS = 0;
  localparam int CLR_OFS = 4;

  logic              clr_hit;
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] flags_vec;

  dma_irq_clr_dec #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_OFS(CLR_OFS)
  ) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .clr_hit  (clr_hit),
    .clr_vec  (clr_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    ch_flags_t ch_clr;
    ch_flags_t ch_flags;

    assign ch_clr = clr_vec[c*FLAGS_PER_CH +: FLAGS_PER_CH];

    dma_irq_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_tc(evt_tc[c]),
      .evt_ht(evt_ht[c]),
      .evt_te(evt_te[c]),
      .clr   (ch_clr),
      .flags (ch_flags),
      .irq   (irq[c])
    );

    assign flags_vec[c*FLAGS_PER_CH +: FLAGS_PER_CH] = ch_flags;
  end

  dma_irq_pack #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_OFS(STS_OFS)
  ) u_pack (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .flags_vec(flags_vec),
    .bus_rdata(bus_rdata)
  );

endmodule

// File: rtl/dma_irq_flags_chk.sv
module dma_irq_flags_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH-1:0]              evt_tc,
  input logic [NUM_CH-1:0]              evt_ht,
  input logic [NUM_CH-1:0]              evt_te,
  input logic                           bus_sel,
  input logic                           bus_wr,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [DATA_W-1:0]              bus_rdata,
  input logic [NUM_CH-1:0]              irq,
  input logic [NUM_CH*FLAGS_PER_CH-1:0] clr_vec,
  input logic [NUM_CH*FLAGS_PER_CH-1:0] flags_vec
);

  logic rd_sts;
  logic rd_clr;

  assign rd_sts = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(0));
  assign rd_clr = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(4));

  // R9: the clear word always reads as zero
  a_r9_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |-> bus_rdata == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam int B = c * FLAGS_PER_CH;
    logic [2:0] evt3;
    assign evt3 = {evt_te[c], evt_ht[c], evt_tc[c]};

    // R7 / R2: an event always leaves its flag set
    a_r7_tc_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_tc[c] |=> flags_vec[B+F_TC]);
    a_r7_ht_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ht[c] |=> flags_vec[B+F_HT]);
    a_r7_te_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_te[c] |=> flags_vec[B+F_TE]);

    // R3: no sub-flag without the summary flag
    a_r3_gif_covers: assert property (@(posedge clk) disable iff (!rst_n)
      (|flags_vec[B+F_TE:B+F_TC]) |-> flags_vec[B+F_GIF]);

    // R4: a specific clear without an event removes that flag
    a_r4_tc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[B+F_TC] && !evt_tc[c] |=> !flags_vec[B+F_TC]);

    // R4: a specific clear leaves the summary flag alone
    a_r4_gif_kept: assert property (@(posedge clk) disable iff (!rst_n)
      flags_vec[B+F_GIF] && !clr_vec[B+F_GIF] |=> flags_vec[B+F_GIF]);

    // R5: a group clear with no event empties the group
    a_r5_group_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[B+F_GIF] && evt3 == 3'b000 |=> flags_vec[B +: FLAGS_PER_CH] == '0);

    // R6: a flag with neither event nor clear holds its value
    a_r6_tc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_tc[c] && !clr_vec[B+F_TC] && !clr_vec[B+F_GIF]
        |=> $stable(flags_vec[B+F_TC]));

    // R8: the interrupt line matches the summary bit seen by a status read
    a_r8_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sts |-> bus_rdata[B+F_GIF] == irq[c]);
  end

endmodule

bind dma_irq_flags dma_irq_flags_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_tc   (evt_tc),
  .evt_ht   (evt_ht),
  .evt_te   (evt_te),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .clr_vec  (clr_vec),
  .flags_vec(flags_vec)
);

// File: tb/dma_irq_flags_test.sv
`timescale 1ns/1ps
module dma_irq_flags_test;

  localparam int NCH = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] evt_tc = '0, evt_ht = '0, evt_te = '0;
  logic           bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [27:0] model = '0;

  always #2 clk = ~clk;

  dma_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .evt_tc(evt_tc), .evt_ht(evt_ht), .evt_te(evt_te),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Independent reference: group x at 4*(x-1); bit0 global, 1 tc, 2 ht, 3 te
  function automatic logic [27:0] ref_next(logic [27:0] cur, logic [NCH-1:0] tc,
      logic [NCH-1:0] ht, logic [NCH-1:0] te, logic wr, logic [7:0] addr,
      logic [31:0] data);
    logic [27:0] nxt;
    logic [27:0] clr;
    clr = (wr && addr == 8'h04) ? data[27:0] : 28'h0;
    nxt = cur;
    for (int c = 0; c < NCH; c++) begin
      if (clr[4*c]) nxt[4*c +: 4] = 4'h0;
      for (int b = 1; b < 4; b++) if (clr[4*c+b]) nxt[4*c+b] = 1'b0;
      if (tc[c]) nxt[4*c+1] = 1'b1;
      if (ht[c]) nxt[4*c+2] = 1'b1;
      if (te[c]) nxt[4*c+3] = 1'b1;
      if (tc[c] | ht[c] | te[c]) nxt[4*c] = 1'b1;
    end
    return nxt;
  endfunction

  function automatic logic [NCH-1:0] ref_irq(logic [27:0] f);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = f[4*c];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then read status and compare (2 checks)
  task automatic step(string tag, logic [NCH-1:0] tc, logic [NCH-1:0] ht,
      logic [NCH-1:0] te, logic wr, logic [7:0] addr, logic [31:0] data);
    evt_tc = tc; evt_ht = ht; evt_te = te;
    bus_sel = wr; bus_wr = wr; bus_addr = addr; bus_wdata = data;
    @(posedge clk);
    model = ref_next(model, tc, ht, te, wr, addr, data);
    @(negedge clk);
    evt_tc = '0; evt_ht = '0; evt_te = '0;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    #1;
    check({tag, " status"}, bus_rdata, {4'h0, model});
    check({tag, " irq"}, 32'(irq), 32'(ref_irq(model)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    bus_sel = 1'b1; bus_addr = 8'h00; #1;
    check("R1 status", bus_rdata, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: tc on channel 3 -> bits 9 and 8; ht ch1 -> bits 2,0; te ch7 -> 27,24
    step("R2", 7'b0000100, '0, '0, 1'b0, 8'h00, 32'h0);
    check("R2 ch3 tc bit9", 32'(bus_rdata[9]), 32'h1);
    check("R3 ch3 gif bit8", 32'(bus_rdata[8]), 32'h1);
    step("R3", '0, 7'b0000001, 7'b1000000, 1'b0, 8'h00, 32'h0);
    check("R3 ch7 te bit27", 32'(bus_rdata[27]), 32'h1);
    // R8: irq lines follow global flags
    check("R8 irq", 32'(irq), 32'h45);

    // R9: clear word reads zero; write to status word is ignored
    bus_addr = 8'h04; #1;
    check("R9 clear word read", bus_rdata, 32'h0);
    step("R9", '0, '0, '0, 1'b1, 8'h00, 32'hFFFF_FFFF);

    // R6: reserved bits and zero bits change nothing
    step("R6", '0, '0, '0, 1'b1, 8'h04, 32'hF000_0000);
    step("R6", '0, '0, '0, 1'b1, 8'h04, 32'h0000_0000);

    // R4: clear only tc of channel 3 (bit 9); global bit 8 stays
    step("R4", '0, '0, '0, 1'b1, 8'h04, 32'h0000_0200);
    check("R4 ch3 gif kept", 32'(bus_rdata[8]), 32'h1);
    check("R8 irq after sub clear", 32'(irq[2]), 32'h1);

    // R7: set and clear of the same flag together -> set wins
    step("R7", '0, '0, 7'b1000000, 1'b1, 8'h04, 32'h0800_0000);
    check("R7 ch7 te kept", 32'(bus_rdata[27]), 32'h1);
    step("R7", '0, 7'b0000001, '0, 1'b1, 8'h04, 32'h0000_0001);
    check("R7 ch1 gif set wins", 32'(bus_rdata[0]), 32'h1);

    // R5: global clear of channel 7 (bit 24) wipes its group
    step("R5", '0, '0, '0, 1'b1, 8'h04, 32'h0100_0000);
    check("R5 ch7 group", 32'(bus_rdata[27:24]), 32'h0);
    check("R8 irq low after clear", 32'(irq[6]), 32'h0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [NCH-1:0] t, h, e;
      logic w;
      logic [7:0] a;
      logic [31:0] d;
      t = NCH'($urandom & $urandom);
      h = NCH'($urandom & $urandom & $urandom);
      e = NCH'($urandom & $urandom & $urandom);
      w = ($urandom % 3) != 0;
      a = ($urandom % 5 == 0) ? 8'h00 : 8'h04;
      d = $urandom & $urandom;
      step("R2 random", t, h, e, w, a, d);
    end

    // Final sweep: group clear of every channel
    step("R5", '0, '0, '0, 1'b1, 8'h04, 32'h0111_1111);
    check("R5 all clear", bus_rdata, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule